// File: doc/BRIEF.md
# Video Sync Frame Measurement Unit

This block measures the timing of an incoming video signal so that firmware can work out the video mode. Between two successive leading (rising) edges of vertical sync it counts two things. One counter counts the horizontal sync pulses, which gives the number of lines per frame. The other counts clock cycles that carry a prescaled tick enable, which gives the frame period. At every vertical leading edge both counts are copied into read-only result registers in the same cycle, and both counters start again from zero.

Each result register saturates at its maximum value instead of wrapping. An overflow flag is captured with each result. The period depends on where the tick enable falls within the frame, so two readings taken at the same frame rate can differ by one count.

A pending interrupt latch is set at each vertical leading edge while the interrupt enable is high. The request output is driven while the latch is set and the global mask is clear. An acknowledge pulse, which stands for the vector fetch, clears the latch. Both sync inputs may be asynchronous to the clock and are resynchronised inside the block.

Top module: `vid_sync_meas`

## Requirements
- R1: Each sync input passes through two synchroniser flops before edge detection. A rising level first sampled at clock edge k counts as a leading edge at edge k+2. A vertical leading edge loads the result registers at that edge k+2.
- R2: `line_cnt_o` holds the number of horizontal leading edges seen in the previous frame. A horizontal leading edge detected in the same cycle as the vertical leading edge counts toward the new frame.
- R3: The line count saturates at 2047. `line_ovf_o` is 1 exactly when more than 2047 horizontal leading edges fell in the reported frame. When it is 1, `line_cnt_o` reads 2047.
- R4: `period_cnt_o` holds the number of clock edges at which `tick_i` was 1, counted from the edge that loaded the previous result (included) up to the edge that loads this one (excluded).
- R5: The period count saturates at 8191. `period_ovf_o` is 1 exactly when more than 8191 ticks fell in the reported frame. When it is 1, `period_cnt_o` reads 8191. The flag is cleared for the following frame.
- R6: All result outputs hold their values between vertical leading edges.
- R7: A vertical leading edge with `irq_en_i` high sets the pending latch. `irq_o` is high while the latch is set and `irq_mask_i` is low. With `irq_en_i` low, the edge leaves the latch unchanged.
- R8: `irq_ack_i` clears the pending latch at the next edge. If a set and an acknowledge arrive in the same cycle, the set wins.
- R9: While `rst_n` is low, all counters, result registers, flags and the pending latch are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, positive polarity, asynchronous |
| vsync_i | input | 1 | Vertical sync, positive polarity, asynchronous |
| tick_i | input | 1 | Prescaled enable for the period counter |
| irq_en_i | input | 1 | Vertical interrupt enable |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks the request |
| irq_ack_i | input | 1 | Acknowledge pulse, clears the pending latch |
| line_cnt_o | output | 11 | Lines in the last frame |
| line_ovf_o | output | 1 | Line count saturated in the last frame |
| period_cnt_o | output | 13 | Ticks in the last frame |
| period_ovf_o | output | 1 | Period count saturated in the last frame |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every vertical sync pulse stays high for at least two clock cycles. This keeps each detected leading edge a single-cycle event that cannot be followed by another within the synchroniser delay. They also assume that `irq_ack_i` is only used as a clearing strobe. The stimulus always holds vertical sync high for three cycles and low for at least three. Horizontal sync levels last one to three cycles, and a horizontal rise is deliberately lined up with every vertical rise. Acknowledges are placed at random steps, including the step at which the latch is being set.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    localparam int unsigned LINE_W_DEF      = 11;
    localparam int unsigned PER_W_DEF       = 13;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic pend;
    } irq_st_t;
endpackage

// File: rtl/vtm_edge_sync.sv
module vtm_edge_sync #(
    parameter int unsigned STAGES = vtm_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    localparam int unsigned W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // last synchroniser stage high, edge-history stage still low
    assign rise_o = st_q.sh[W-2] & ~st_q.sh[W-1];
endmodule

// File: rtl/vtm_sat_counter.sv
module vtm_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         inc,
    output logic [W-1:0] snap_o,
    output logic         snap_ovf_o
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
        logic [W-1:0] snap;
        logic         snap_ovf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.snap     = st_q.cnt;
            st_d.snap_ovf = st_q.ovf;
            st_d.cnt      = {{(W-1){1'b0}}, inc};
            st_d.ovf      = 1'b0;
        end else if (inc) begin
            if (st_q.cnt == MAXV) st_d.ovf = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_o     = st_q.snap;
    assign snap_ovf_o = st_q.snap_ovf;
endmodule

// File: rtl/vtm_irq.sv
module vtm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic mask_i,
    output logic pend_o,
    output logic irq_o
);
    import vtm_pkg::*;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.pend = 1'b1;
        else if (ack_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.pend & ~mask_i;
endmodule

// File: rtl/vid_sync_meas.sv
module vid_sync_meas #(
    parameter int unsigned LINE_W      = vtm_pkg::LINE_W_DEF,
    parameter int unsigned PER_W       = vtm_pkg::PER_W_DEF,
    parameter int unsigned SYNC_STAGES = vtm_pkg::SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              tick_i,
    input  logic              irq_en_i,
    input  logic              irq_mask_i,
    input  logic              irq_ack_i,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic              line_ovf_o,
    output logic [PER_W-1:0]  period_cnt_o,
    output logic              period_ovf_o,
    output logic              irq_o
);
    logic hs_rise;
    logic vs_rise;
    logic irq_pend;

    vtm_edge_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (hsync_i),
        .rise_o (hs_rise)
    );

    vtm_edge_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (vsync_i),
        .rise_o (vs_rise)
    );

    vtm_sat_counter #(.W(LINE_W)) u_line_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (vs_rise),
        .inc        (hs_rise),
        .snap_o     (line_cnt_o),
        .snap_ovf_o (line_ovf_o)
    );

    vtm_sat_counter #(.W(PER_W)) u_period_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (vs_rise),
        .inc        (tick_i),
        .snap_o     (period_cnt_o),
        .snap_ovf_o (period_ovf_o)
    );

    vtm_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (vs_rise & irq_en_i),
        .ack_i  (irq_ack_i),
        .mask_i (irq_mask_i),
        .pend_o (irq_pend),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/vtm_checker.sv
module vtm_checker #(
    parameter int unsigned LINE_W = 11,
    parameter int unsigned PER_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vs_rise,
    input logic              irq_en_i,
    input logic              irq_ack_i,
    input logic              irq_pend,
    input logic [LINE_W-1:0] line_cnt_o,
    input logic              line_ovf_o,
    input logic [PER_W-1:0]  period_cnt_o,
    input logic              period_ovf_o
);
    localparam logic [LINE_W-1:0] LMAX = '1;
    localparam logic [PER_W-1:0]  PMAX = '1;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) vs_rise |=> !vs_rise); // R1
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(line_cnt_o) && $stable(period_cnt_o) && $stable(line_ovf_o) && $stable(period_ovf_o)); // R6
    AST_LINE_SAT: assert property (@(posedge clk) disable iff (!rst_n) line_ovf_o |-> line_cnt_o == LMAX); // R3
    AST_PERIOD_SAT: assert property (@(posedge clk) disable iff (!rst_n) period_ovf_o |-> period_cnt_o == PMAX); // R5
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n) vs_rise && irq_en_i |=> irq_pend); // R7
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_pend) |-> $past(vs_rise && irq_en_i)); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i && !(vs_rise && irq_en_i) |=> !irq_pend); // R8
endmodule

bind vid_sync_meas vtm_checker #(.LINE_W(LINE_W), .PER_W(PER_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vs_rise      (vs_rise),
    .irq_en_i     (irq_en_i),
    .irq_ack_i    (irq_ack_i),
    .irq_pend     (irq_pend),
    .line_cnt_o   (line_cnt_o),
    .line_ovf_o   (line_ovf_o),
    .period_cnt_o (period_cnt_o),
    .period_ovf_o (period_ovf_o)
);

// File: tb/sim_vid_sync_meas.sv
`timescale 1ns/1ps
module sim_vid_sync_meas;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_i = 1'b0, vsync_i = 1'b0, tick_i = 1'b0;
    logic irq_en_i = 1'b0, irq_mask_i = 1'b0, irq_ack_i = 1'b0;
    logic [10:0] line_cnt_o;
    logic        line_ovf_o;
    logic [12:0] period_cnt_o;
    logic        period_ovf_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vid_sync_meas u0 (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i), .tick_i(tick_i),
        .irq_en_i(irq_en_i), .irq_mask_i(irq_mask_i), .irq_ack_i(irq_ack_i),
        .line_cnt_o(line_cnt_o), .line_ovf_o(line_ovf_o), .period_cnt_o(period_cnt_o),
        .period_ovf_o(period_ovf_o), .irq_o(irq_o)
    );

    // reference state derived from the requirements
    bit prev_h = 0, prev_v = 0;
    bit [1:0] vdly = '0;
    int lines = 0, ticks = 0, line_pending = 0;
    bit pend = 0;

    function automatic int sat(input int v, input int m);
        return (v > m) ? m : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit h, input bit v, input bit t, input bit a, input bit en, input bit msk);
        bit hr, vr, bnd;
        @(negedge clk);
        hsync_i = h; vsync_i = v; tick_i = t; irq_ack_i = a; irq_en_i = en; irq_mask_i = msk;
        @(posedge clk);
        #1;
        hr = h & !prev_h; vr = v & !prev_v;
        prev_h = h; prev_v = v;
        // line events share the sync delay with vsync, so frame them at the input step (R2)
        if (vr) begin
            line_pending = lines;
            lines = hr;
        end else if (hr) lines++;
        // ticks are unsynchronised: boundary lands two edges later (R1, R4)
        bnd = vdly[1];
        vdly = {vdly[0], vr};
        if (bnd) begin
            chk(period_cnt_o == sat(ticks, 8191), "R4/R5 period", period_cnt_o, sat(ticks, 8191));
            chk(period_ovf_o == (ticks > 8191), "R5 period overflow", period_ovf_o, ticks > 8191);
            chk(line_cnt_o == sat(line_pending, 2047), "R2/R3 lines", line_cnt_o, sat(line_pending, 2047));
            chk(line_ovf_o == (line_pending > 2047), "R3 line overflow", line_ovf_o, line_pending > 2047);
            ticks = t;
        end else ticks += t;
        if (bnd && en) pend = 1;        // R7, set wins over ack (R8)
        else if (a)   pend = 0;
        chk(irq_o == (pend & !msk), "R7/R8 irq", irq_o, pend & !msk);
    endtask

    task automatic frame(input int nl, input int tp, input bit en, input bit msk, input int ack_at);
        int s = 0;
        for (int l = 0; l < nl; l++) begin
            int hw = $urandom_range(1, 3);
            int lw = $urandom_range(1, 3);
            for (int c = 0; c < hw + lw; c++) begin
                step(c < hw, s < 3, $urandom_range(0, 99) < tp, s == ack_at, en, msk);
                s++;
            end
        end
        while (s < 6) begin
            step(1'b0, s < 3, $urandom_range(0, 99) < tp, s == ack_at, en, msk);
            s++;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(line_cnt_o == 0 && period_cnt_o == 0, "R9 reset counts", line_cnt_o + period_cnt_o, 0);
        chk(!line_ovf_o && !period_ovf_o && !irq_o, "R9 reset flags", line_ovf_o + period_ovf_o + irq_o, 0);
        @(negedge clk) rst_n = 1'b1;

        // R1/R2: first frame, horizontal rise coincides with vertical rise
        frame(5, 100, 1'b0, 1'b0, -1);
        frame(8, 50, 1'b1, 1'b0, -1);
        // R7: masked request stays low while pending, appears when unmasked
        frame(4, 30, 1'b1, 1'b1, -1);
        frame(4, 30, 1'b0, 1'b0, 10);           // R8 ack clears
        frame(3, 30, 1'b1, 1'b0, 2);            // R8 ack in the set cycle
        frame(6, 80, 1'b0, 1'b0, -1);           // R7 enable low: no set
        // R5: period saturation
        frame(1, 100, 1'b0, 1'b0, -1);
        for (int i = 0; i < 8300; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        frame(2, 100, 1'b0, 1'b0, -1);
        // R3: line saturation
        for (int i = 0; i < 2100; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        frame(2, 10, 1'b0, 1'b0, -1);
        // random frames (R2, R4, R6, R7, R8)
        for (int f = 0; f < 30; f++)
            frame($urandom_range(0, 60), $urandom_range(0, 100), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), $urandom_range(0, 40));
        frame(0, 50, 1'b0, 1'b0, -1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule